// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a memory controller and an external SRAM and gates the SRAM's active-low chip enable while the supply is failing. While the supply is good, the enable passes straight through. When an external comparator raises its power-fail flag, an access that is already in progress may finish, but only inside a bounded grace window. After that the enable is held inactive until the supply is good again and the requester has released the enable at least once.

The power-fail flag comes from an analog comparator and is asynchronous, so it passes through a synchronizer of `SYNC_STAGES` flops before the gate acts on it. The grace window is `GRACE_CYCLES` clock cycles. By default it is derived from the clock rate in kHz and the window length in ns, rounding up. A tolerance select bit, which picks the wider or narrower supply band, is passed to the comparator unchanged. The comparator, the threshold levels and supply switching are outside this block. No data flows through the block, so all pins are plain control signals with no handshake.

Top module: `pfg_ce_guard`

## Requirements
- R1: While the synchronous reset `rst` is sampled high, the block enters the protected state: `ce_out_n` reads 1 in the cycle after that clock edge.
- R2: When no power failure is recognised and the block is in pass mode, `ce_out_n` equals `ce_req_n` combinationally, and `ce_out_n` is never low unless `ce_req_n` is low.
- R3: Suppose `pwr_fail` is high at clock edge k. The block then recognises the failure at edge k+SYNC_STAGES, which is k+2 by default. Until that edge the output keeps following the input.
- R4: If `ce_req_n` is low at the edge where the failure is recognised, `ce_out_n` keeps following `ce_req_n` while it stays low. Once `ce_req_n` is sampled high, the output is high from then on.
- R5: If `ce_req_n` stays low, `ce_out_n` is forced high starting with the clock edge that falls GRACE_CYCLES edges after the recognition edge, whatever the input does.
- R6: If `ce_req_n` is high at the recognition edge, `ce_out_n` is high from that edge onward.
- R7: Once `ce_out_n` has been forced high during a failure, a new low on `ce_req_n` does not bring it low again while the failure lasts.
- R8: After the synchronized flag clears, `ce_out_n` stays high until `ce_req_n` is sampled high with no failure recognised. From the next cycle on it follows the input.
- R9: `cmp_tol_sel` always carries the value of `tol_sel`. A value of 0 selects the narrow band and 1 selects the wide band.
- R10: The default GRACE_CYCLES is ceil(GRACE_NS × CLK_KHZ / 10^6). That is 75 cycles for a 1500 ns window at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_req_n | input | 1 | Chip-enable request from the controller, active low |
| pwr_fail | input | 1 | Asynchronous power-fail flag from the comparator, high = failing |
| tol_sel | input | 1 | Supply tolerance select (0 narrow, 1 wide) |
| ce_out_n | output | 1 | Gated chip enable to the SRAM, active low |
| cmp_tol_sel | output | 1 | Tolerance select forwarded to the comparator |

## Verification
On every cycle, the assertions check four things: the output is never active without a request, an input sampled high during a recognised failure drives the output high, a forced-high output stays high while the input is low, and the output never stays active across a failure for more than the grace window. Some behaviour can only be shown by the bench's scenarios. These are the exact synchronizer latency, the precise cycle on which the timeout fires for the default window, the one-release rule after the supply recovers, and the forwarding of the tolerance bit.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    PG_PROTECT = 2'd0,
    PG_PASS    = 2'd1,
    PG_GRACE   = 2'd2
  } pfg_state_e;

  function automatic int grace_from_time(input int clk_khz, input int window_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(window_ns);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= {STAGES{RESET_VAL}};
        end else if (STAGES == 1) begin
          chain[0] <= d_async;
        end else begin
          chain <= {chain[STAGES-2:0], d_async};
        end
      end
      assign q_sync = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pfg_grace_timer.sv
module pfg_grace_timer #(
  parameter int LIMIT = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       fail,
  input  logic       expired,
  output pfg_state_e state,
  output logic       timer_run
);

  pfg_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PG_PASS: begin
        if (fail) nxt = req_n ? PG_PROTECT : PG_GRACE;
      end
      PG_GRACE: begin
        if (req_n || expired) nxt = PG_PROTECT;
      end
      PG_PROTECT: begin
        if (!fail && req_n) nxt = PG_PASS;
      end
      default: nxt = PG_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PG_PROTECT;
    else     state <= nxt;
  end

  assign timer_run = (state == PG_GRACE);

endmodule

// File: rtl/pfg_ce_guard.sv
module pfg_ce_guard
  import pfg_pkg::*;
#(
  parameter int CLK_KHZ      = 50000,
  parameter int GRACE_NS     = 1500,
  parameter int GRACE_CYCLES = grace_from_time(CLK_KHZ, GRACE_NS),
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_req_n,
  input  logic pwr_fail,
  input  logic tol_sel,
  output logic ce_out_n,
  output logic cmp_tol_sel
);

  localparam int LIMIT = (GRACE_CYCLES < 1) ? 1 : GRACE_CYCLES;

  logic       fail_sync;
  logic       expired;
  logic       timer_run;
  pfg_state_e state;

  pfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pwr_fail),
    .q_sync  (fail_sync)
  );

  pfg_grace_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (timer_run),
    .expired (expired)
  );

  pfg_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_n     (ce_req_n),
    .fail      (fail_sync),
    .expired   (expired),
    .state     (state),
    .timer_run (timer_run)
  );

  always_comb begin
    unique case (state)
      PG_PASS, PG_GRACE: ce_out_n = ce_req_n;
      default:           ce_out_n = 1'b1;
    endcase
  end

  assign cmp_tol_sel = tol_sel;

endmodule

// File: rtl/pfg_ce_guard_checker.sv
module pfg_ce_guard_checker #(
  parameter int GRACE_CYCLES = 75
) (
  input logic clk,
  input logic rst,
  input logic ce_req_n,
  input logic ce_out_n,
  input logic fail_seen
);

  localparam int RW = $clog2(GRACE_CYCLES + 3);
  localparam logic [RW-1:0] RMAX = RW'(GRACE_CYCLES + 2);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || !(fail_seen && !ce_out_n)) low_run <= '0;
    else if (low_run != RMAX)             low_run <= low_run + 1'b1;
  end

  AST_RESET_PROTECTS: assert property (@(posedge clk)
    rst |=> ce_out_n); // R1

  AST_NO_SPURIOUS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !ce_out_n |-> !ce_req_n); // R2

  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (fail_seen && ce_req_n) |=> ce_out_n); // R4

  AST_GRACE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (fail_seen && !ce_out_n) |-> (low_run <= RW'(GRACE_CYCLES))); // R5

  AST_LATCHED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ce_out_n && !ce_req_n) |=> ce_out_n); // R7

endmodule

bind pfg_ce_guard pfg_ce_guard_checker #(.GRACE_CYCLES(LIMIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_req_n  (ce_req_n),
  .ce_out_n  (ce_out_n),
  .fail_seen (fail_sync)
);

// File: tb/pfg_ce_guard_bench.sv
module pfg_ce_guard_bench;

  localparam int CLK_NS    = 20;
  localparam int EXP_GRACE = (1500 + CLK_NS - 1) / CLK_NS; // R10: 75 at 50 MHz

  typedef struct {
    logic  out_n;
    logic  tol;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_req_n = 1'b1;
  logic pwr_fail = 1'b1;
  logic tol_sel = 1'b0;
  logic ce_out_n;
  logic cmp_tol_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  pfg_ce_guard u_pfg_ce_guard (
    .clk         (clk),
    .rst         (rst),
    .ce_req_n    (ce_req_n),
    .pwr_fail    (pwr_fail),
    .tol_sel     (tol_sel),
    .ce_out_n    (ce_out_n),
    .cmp_tol_sel (cmp_tol_sel)
  );

  task automatic run(input int n, input logic rq, input logic pf, input logic tl,
                     input logic exp_out, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      ce_req_n = rq;
      pwr_fail = pf;
      tol_sel  = tl;
      e.out_n = exp_out;
      e.tol   = tl;
      e.tag   = tag;
      sb.push_back(e);
    end
  endtask

  // monitor: pops one expected item per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (ce_out_n !== e.out_n) begin
          fails++;
          $display("FAIL %s ce_out_n actual=%b expected=%b at %0t", e.tag, ce_out_n, e.out_n, $time);
        end
        checks++;
        if (cmp_tol_sel !== e.tol) begin
          fails++;
          $display("FAIL R9 cmp_tol_sel actual=%b expected=%b at %0t", cmp_tol_sel, e.tol, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: held in reset, output protected
    run(3, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
    rst = 1'b0;
    // R8: after reset the flag clears through the synchronizer
    run(3, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
    // R2: pass mode follows input
    run(1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    run(1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    run(2, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    run(1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    // R3/R6: failure while idle
    run(3, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    run(1, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
    run(4, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    // R8: supply good but input still low keeps protection
    run(6, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    run(1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    run(1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    run(1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    // R3/R4: access in flight, released by the requester
    run(3, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    run(3, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    run(1, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
    run(3, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
    run(4, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    run(1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    run(1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    // R5/R10: access in flight that never ends, cut at the grace limit
    run(3, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    run(EXP_GRACE, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    run(3, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
    run(4, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    run(1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule